// File: doc/BRIEF.md
# Serial ADC Command/Response Engine

This block is the digital side of a 10-bit successive-approximation converter with eight multiplexed analog inputs, reached over a four-wire SPI-compatible port. The serial pins are oversampled by the chip clock. While chip select is low, the engine looks for a start bit on the data input. It then takes in a single-ended/differential flag and a 3-bit channel field, and raises a sample-window strobe for the analog front end. It then resolves the result one bit per falling serial-clock edge against a comparator decision, and serialises a low null bit followed by the result.

After the MSB-first result, further clocks return the same code LSB-first, and zeros follow after that. Raising chip select aborts the frame, disables the output driver and flags standby. After reset with chip select already low, the engine stays locked until chip select has been high once. The analog sample/hold, the capacitor DAC and the comparator are outside the block: it presents the trial word and the channel selection, and receives a one-bit comparator decision.

Top module: `adcSerialEngine`

## Requirements
- R1: After reset with chip select low, no start bit is accepted (no sample window and no output enable) until chip select has gone high and then low again.
- R2: With chip select low, data-input zeros sampled on rising serial-clock edges are ignored; the first rising edge that samples a one is the start bit.
- R3: The next four rising edges capture, in order, the mode bit (1 = single-ended, 0 = differential) and channel bits D2, D1, D0. `sampleWin` rises after the 4th of these edges and falls on the falling edge that follows the 5th rising edge, whose data input is ignored.
- R4: In single-ended mode `muxPos` = D2D1D0, `muxNeg` = 0 and `diffMode` = 0. In differential mode `diffMode` = 1, D2D1 picks the pair {2k, 2k+1}, and D0 = 0 makes the even channel IN+ while D0 = 1 makes the odd channel IN+; `muxNeg` is the other member of the pair.
- R5: `spiDoutEn` is 0 from chip select fall until the falling edge that closes the sample window. On that edge it goes to 1 and `spiDout` drives a low null bit. The next 10 falling edges drive B9 down to B0.
- R6: One result bit is resolved per falling edge, from B9 down to B0. Each trial bit is kept when `cmpIn` is 1 (input at or above `sarTrial`) and cleared otherwise. The result is straight binary, 000h to 3FFh.
- R7: On further falling edges after B0 with chip select low, the output drives B1 up to B9 (B0 is not repeated) and then zeros indefinitely.
- R8: Raising chip select ends any frame in progress and clears `spiDoutEn` within one clock. A later frame needs a new start bit.
- R9: Only edge direction matters, so frames work whether the serial clock idles low (mode 0,0) or high (mode 1,1).
- R10: `standby` is 1 one clock after chip select is sampled high and 0 one clock after it is sampled low; it is 1 out of reset.
- R11: After a frame, further start-bit patterns with chip select still low start no new conversion. The output keeps driving zeros and `sampleWin` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| spiClk | input | 1 | Serial clock, synchronous to clk |
| spiCsN | input | 1 | Active-low chip select |
| spiDin | input | 1 | Serial command data |
| cmpIn | input | 1 | Comparator decision, 1 when input is at or above the trial word |
| spiDout | output | 1 | Serial result data |
| spiDoutEn | output | 1 | Output driver enable; pad is high-impedance when 0 |
| standby | output | 1 | Low-power indication while chip select is high |
| sampleWin | output | 1 | Sample/hold acquire window |
| sarTrial | output | 10 | Current trial word for the DAC |
| muxPos | output | 3 | Channel routed to the positive input |
| muxNeg | output | 3 | Channel routed to the negative input (differential) |
| diffMode | output | 1 | 1 when the captured command is differential |

## Verification
The assertions take for granted that the serial pins are already synchronous to `clk` and that each serial-clock level lasts at least two clock cycles, so that every edge is seen once. They also assume `cmpIn` has settled for the current `sarTrial` by the next serial falling edge. The stimulus changes pins only on the falling edge of `clk` and holds each serial half period for eight clocks. It models the comparator as a direct compare of a per-channel level against `sarTrial`, so these assumptions hold throughout.

// File: rtl/adcSerPkg.sv
package adcSerPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_CMD,
    ST_SAMPLE,
    ST_CONV,
    ST_MIRROR,
    ST_ZERO
  } engStateT;

  // strobes from control to datapath, at most one per clock
  typedef struct packed {
    logic capCmd;
    logic sarInit;
    logic sarStep;
    logic mirror;
    logic zeroFill;
  } ctrlStrobeT;

endpackage

// File: rtl/adcSerCtrl.sv
module adcSerCtrl
  import adcSerPkg::*;
#(
  parameter int RES_W  = 10,
  parameter int CHAN_W = 3,
  localparam int CMD_W = CHAN_W + 1,
  localparam int IDX_W = $clog2(RES_W),
  localparam int CNT_W = $clog2(RES_W + CMD_W + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             csN,
  input  logic             din,
  output ctrlStrobeT       strb,
  output logic [IDX_W-1:0] bitIdx,
  output logic             doutEn,
  output logic             sampleWin,
  output logic             standby
);

  engStateT         state;
  logic             armed;
  logic             sclkQ;
  logic [CNT_W-1:0] cnt;
  logic             rise;
  logic             fall;

  assign rise = sclk & ~sclkQ & ~csN;
  assign fall = ~sclk & sclkQ & ~csN;

  always_comb begin
    strb          = '0;
    strb.capCmd   = (state == ST_CMD) && rise;
    strb.sarInit  = (state == ST_SAMPLE) && fall && (cnt == CNT_W'(CMD_W + 1));
    strb.sarStep  = (state == ST_CONV) && fall;
    strb.mirror   = (state == ST_MIRROR) && fall;
    strb.zeroFill = (state == ST_ZERO) && fall;
  end

  // mirror sends B1 upward; B0 is not repeated
  assign bitIdx = IDX_W'(cnt + CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      armed     <= 1'b0;
      sclkQ     <= 1'b0;
      cnt       <= '0;
      doutEn    <= 1'b0;
      sampleWin <= 1'b0;
      standby   <= 1'b1;
    end else begin
      sclkQ   <= sclk;
      standby <= csN;
      if (csN) begin
        state     <= ST_IDLE;
        armed     <= 1'b1;
        cnt       <= '0;
        doutEn    <= 1'b0;
        sampleWin <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (armed) begin
              state <= ST_HUNT;
              armed <= 1'b0;
            end
          end
          ST_HUNT: begin
            if (rise && din) begin
              state <= ST_CMD;
              cnt   <= '0;
            end
          end
          ST_CMD: begin
            if (rise) begin
              cnt <= cnt + CNT_W'(1);
              if (cnt == CNT_W'(CMD_W - 1)) begin
                state     <= ST_SAMPLE;
                sampleWin <= 1'b1;
              end
            end
          end
          ST_SAMPLE: begin
            if (rise && (cnt == CNT_W'(CMD_W))) begin
              cnt <= cnt + CNT_W'(1);
            end
            if (strb.sarInit) begin
              sampleWin <= 1'b0;
              doutEn    <= 1'b1;
              state     <= ST_CONV;
              cnt       <= '0;
            end
          end
          ST_CONV: begin
            if (fall) begin
              if (cnt == CNT_W'(RES_W - 1)) begin
                state <= ST_MIRROR;
                cnt   <= '0;
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
          end
          ST_MIRROR: begin
            if (fall) begin
              if (cnt == CNT_W'(RES_W - 2)) begin
                state <= ST_ZERO;
                cnt   <= '0;
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
          end
          default: begin
            state <= ST_ZERO;
          end
        endcase
      end
    end
  end

  // R8: chip select high disables the driver on the next clock
  assert_oe_off_on_cs_R8 : assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !doutEn);

  // R10: standby follows chip select one clock later
  assert_standby_high_R10 : assert property (@(posedge clk) disable iff (!rstN)
    csN |=> standby);
  assert_standby_low_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> !standby);

  // R5: driver stays off while acquiring
  assert_win_no_drive_R5 : assert property (@(posedge clk) disable iff (!rstN)
    sampleWin |-> !doutEn);

  // R5: driver turns on only as the window closes
  assert_oe_after_win_R5 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutEn) |-> $past(sampleWin));

  // R6: strobes are mutually exclusive
  assert_strobe_excl_R6 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capCmd, strb.sarInit, strb.sarStep, strb.mirror, strb.zeroFill}));

  // R1: a locked engine never opens a window
  assert_lockout_R1 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !armed && !csN) |=> !sampleWin);

endmodule

// File: rtl/adcSerData.sv
module adcSerData
  import adcSerPkg::*;
#(
  parameter int RES_W  = 10,
  parameter int CHAN_W = 3,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              din,
  input  logic              cmpIn,
  input  ctrlStrobeT        strb,
  input  logic [IDX_W-1:0]  bitIdx,
  output logic              dout,
  output logic [RES_W-1:0]  sarTrial,
  output logic [CHAN_W-1:0] muxPos,
  output logic [CHAN_W-1:0] muxNeg,
  output logic              diffMode
);

  logic [CHAN_W:0]    cmdReg;
  logic [RES_W-1:0]   resReg;
  logic [RES_W-1:0]   maskReg;
  logic [CHAN_W-1:0]  chanSel;

  assign chanSel  = cmdReg[CHAN_W-1:0];
  assign diffMode = ~cmdReg[CHAN_W];
  // in differential mode the low channel bit picks which pair member is IN+
  assign muxPos   = chanSel;
  assign muxNeg   = diffMode ? (chanSel ^ CHAN_W'(1)) : '0;
  assign sarTrial = resReg | maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      resReg  <= '0;
      maskReg <= '0;
      dout    <= 1'b0;
    end else begin
      if (strb.capCmd) begin
        cmdReg <= {cmdReg[CHAN_W-1:0], din};
      end
      if (strb.sarInit) begin
        resReg  <= '0;
        maskReg <= {1'b1, {(RES_W-1){1'b0}}};
        dout    <= 1'b0;
      end
      if (strb.sarStep) begin
        if (cmpIn) begin
          resReg <= resReg | maskReg;
        end
        maskReg <= maskReg >> 1;
        dout    <= cmpIn;
      end
      if (strb.mirror) begin
        dout <= resReg[bitIdx];
      end
      if (strb.zeroFill) begin
        dout <= 1'b0;
      end
    end
  end

  // R6: exactly one trial bit at a time, or none when finished
  assert_mask_onehot_R6 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(maskReg));

  // R6: never step past the LSB
  assert_step_in_range_R6 : assert property (@(posedge clk) disable iff (!rstN)
    strb.sarStep |-> (maskReg != '0));

  // R6: a low decision leaves the decided bits untouched
  assert_clear_keeps_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (strb.sarStep && !cmpIn) |=> $stable(resReg));

  // R5: the null bit is low
  assert_null_low_R5 : assert property (@(posedge clk) disable iff (!rstN)
    strb.sarInit |=> !dout);

endmodule

// File: rtl/adcSerialEngine.sv
module adcSerialEngine
  import adcSerPkg::*;
#(
  parameter int RES_W  = 10,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiClk,
  input  logic              spiCsN,
  input  logic              spiDin,
  input  logic              cmpIn,
  output logic              spiDout,
  output logic              spiDoutEn,
  output logic              standby,
  output logic              sampleWin,
  output logic [RES_W-1:0]  sarTrial,
  output logic [CHAN_W-1:0] muxPos,
  output logic [CHAN_W-1:0] muxNeg,
  output logic              diffMode
);

  localparam int IDX_W = $clog2(RES_W);

  ctrlStrobeT       strb;
  logic [IDX_W-1:0] bitIdx;

  adcSerCtrl #(.RES_W(RES_W), .CHAN_W(CHAN_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclk      (spiClk),
    .csN       (spiCsN),
    .din       (spiDin),
    .strb      (strb),
    .bitIdx    (bitIdx),
    .doutEn    (spiDoutEn),
    .sampleWin (sampleWin),
    .standby   (standby)
  );

  adcSerData #(.RES_W(RES_W), .CHAN_W(CHAN_W)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .din      (spiDin),
    .cmpIn    (cmpIn),
    .strb     (strb),
    .bitIdx   (bitIdx),
    .dout     (spiDout),
    .sarTrial (sarTrial),
    .muxPos   (muxPos),
    .muxNeg   (muxNeg),
    .diffMode (diffMode)
  );

endmodule

// File: tb/test_adcSerialEngine.sv
module test_adcSerialEngine;

  localparam int HALF = 8;
  localparam int NVEC = 14;
  // vector: [7] single-ended, [6:4] channel, [3] clock idles high, [2:0] leading zeros
  localparam logic [7:0] VEC [NVEC] = '{
    8'h80, 8'h9B, 8'hA7, 8'hB9, 8'hC2, 8'hD8, 8'hE5,
    8'hFC, 8'h00, 8'h1A, 8'h21, 8'h5B, 8'h60, 8'h7E
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic din = 1'b0;
  logic cmpIn;
  logic spiDout, spiDoutEn, standby, sampleWin, diffMode;
  logic [9:0] sarTrial;
  logic [2:0] muxPos, muxNeg;

  int ana [8] = '{1023, 0, 700, 300, 512, 511, 5, 1000};
  int nChecks = 0;
  int nFail = 0;
  bit cpol = 1'b0;
  bit done = 1'b0;
  logic sDout, sEn, sWin;
  logic [2:0] sPos, sNeg;
  logic sDiff;

  always #5 clk = ~clk;

  adcSerialEngine i_adcSerialEngine (
    .clk(clk), .rstN(rstN), .spiClk(sclk), .spiCsN(csN), .spiDin(din),
    .cmpIn(cmpIn), .spiDout(spiDout), .spiDoutEn(spiDoutEn), .standby(standby),
    .sampleWin(sampleWin), .sarTrial(sarTrial), .muxPos(muxPos), .muxNeg(muxNeg),
    .diffMode(diffMode)
  );

  // comparator model
  always_comb begin
    int vin;
    vin = ana[muxPos] - (diffMode ? ana[muxNeg] : 0);
    if (vin < 0) vin = 0;
    if (vin > 1023) vin = 1023;
    cmpIn = (vin >= int'(sarTrial));
  end

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic halfWait;
    repeat (HALF) @(negedge clk);
  endtask

  // one serial clock; outputs sampled just before its rising edge
  task automatic spiCycle(input logic b);
    din = b;
    if (cpol) sclk = 1'b0;
    halfWait();
    sDout = spiDout; sEn = spiDoutEn; sWin = sampleWin;
    sPos = muxPos; sNeg = muxNeg; sDiff = diffMode;
    sclk = 1'b1;
    halfWait();
    if (!cpol) sclk = 1'b0;
  endtask

  task automatic runFrame(input logic [7:0] v, input bit holdAfter);
    bit single;
    logic [2:0] ch;
    int pos, neg, code;
    string tr;
    single = v[7];
    ch = v[6:4];
    cpol = v[3];
    tr = cpol ? "R9" : "R6";
    pos = ch;
    neg = single ? 0 : (ch ^ 3'd1);
    code = single ? ana[pos] : ana[pos] - ana[neg];
    if (code < 0) code = 0;
    sclk = cpol;
    halfWait();
    csN = 1'b0;
    halfWait();
    check("R10 standby low", standby, 0);
    for (int z = 0; z < v[2:0]; z++) begin
      spiCycle(1'b0);
      check("R2 lead zero no drive", sEn, 0);
    end
    spiCycle(1'b1);
    check("R5 hi-Z before start", sEn, 0);
    spiCycle(single);
    check("R3 no window at mode", sWin, 0);
    for (int k = 2; k >= 0; k--) begin
      spiCycle(ch[k]);
      check("R3 no window at chan", sWin, 0);
    end
    spiCycle(1'b1);
    check("R3 window open", sWin, 1);
    check("R5 hi-Z in window", sEn, 0);
    check("R4 muxPos", sPos, pos);
    check("R4 muxNeg", sNeg, neg);
    check("R4 diffMode", sDiff, single ? 0 : 1);
    spiCycle(1'b0);
    check("R3 window closed", sWin, 0);
    check("R5 drive on", sEn, 1);
    check("R5 null bit", sDout, 0);
    for (int b = 9; b >= 0; b--) begin
      spiCycle(1'b0);
      check({tr, " msb-first bit"}, sDout, (code >> b) & 1);
    end
    for (int b = 1; b <= 9; b++) begin
      spiCycle(1'b1);
      check("R7 lsb-first bit", sDout, (code >> b) & 1);
    end
    for (int z = 0; z < 2; z++) begin
      spiCycle(1'b0);
      check("R7 zero fill", sDout, 0);
      check("R7 still driving", sEn, 1);
    end
    if (holdAfter) begin
      spiCycle(1'b1);
      spiCycle(1'b1);
      for (int z = 0; z < 8; z++) begin
        spiCycle(1'b0);
        check("R11 no restart window", sWin, 0);
        check("R11 zeros continue", sDout, 0);
      end
    end
    halfWait();
    csN = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 drive off after cs high", spiDoutEn, 0);
    check("R10 standby high", standby, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // reset state
    check("R10 reset standby", standby, 1);
    check("R5 reset no drive", spiDoutEn, 0);
    check("R3 reset no window", sampleWin, 0);

    // R1: reset with chip select low locks the engine
    csN = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cpol = 1'b0;
    sclk = 1'b0;
    halfWait();
    spiCycle(1'b1);
    spiCycle(1'b1);
    for (int k = 0; k < 16; k++) begin
      spiCycle(k[0]);
      check("R1 locked no window", sWin, 0);
      check("R1 locked no drive", sEn, 0);
    end
    csN = 1'b1;
    halfWait();

    for (int i = 0; i < NVEC; i++) begin
      runFrame(VEC[i], 1'b0);
    end

    // R8: abort mid-conversion, then a clean frame
    cpol = 1'b0;
    sclk = 1'b0;
    csN = 1'b0;
    halfWait();
    spiCycle(1'b1);
    spiCycle(1'b1);
    spiCycle(1'b0);
    spiCycle(1'b1);
    spiCycle(1'b1);
    spiCycle(1'b0);
    spiCycle(1'b0);
    check("R8 drive on before abort", sEn, 1);
    spiCycle(1'b0);
    spiCycle(1'b0);
    csN = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 abort drive off", spiDoutEn, 0);
    check("R8 abort standby", standby, 1);
    halfWait();
    runFrame(8'hB0, 1'b0);

    // R11: no second conversion without chip select high
    runFrame(8'hA1, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R8 watchdog expired: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule